// File: doc/BRIEF.md
# Externally Clocked Serial Transmitter with Holding Register

This block sends words one bit at a time on a single data line. It has no baud generator of its own. Bits advance on falling edges of an external clock input that another part of the chip produces. That input is brought into the system clock domain through a two-stage synchronizer, and its falling edges are detected there. Bits leave least significant first. Because the data line changes on the falling edge, a receiver that samples on the rising edge, with the clock idling low, sees every bit stable.

There are two storage stages: the shift register and one holding word. A word written while the channel is off goes straight into the shift register, so its first bit is on the line at once. Writes made after the channel is on go to the holding word. When the current word ends, the holding word moves into the shift register on that same falling edge, and a status flag then tells software that it may write again. No output reports that the last word has finished leaving the shift register.

The word length is set from 1 to 32 bits. Two modes are available. In continuous mode the line keeps its last bit when nothing is waiting. In single-word mode the line returns low after each word and waits for a new write.

Top module: `sst_tx_top`

## Requirements
- R1: After reset, `sdo` and `buf_empty` are 0, the word length is 8 bits and continuous mode is selected.
- R2: A write while `enable` is low loads `wr_data` into the shift register, so bit 0 of the word is on `sdo` from the next cycle. The load captures the word length that is current at that moment.
- R3: While enabled, each detected falling edge of `ext_clk` advances `sdo` by one bit, least significant bit first. A word holds `cfg_in[4:0]`+1 bits, from 1 to 32.
- R4: A write while enabled fills the holding word. On the falling edge that ends the current word, or on the next falling edge if the shifter is already idle, the holding word moves into the shifter and its bit 0 appears on `sdo`, with no gap.
- R5: `buf_empty` rises on the cycle after the holding word moves into the shifter. A write while enabled clears it.
- R6: In continuous mode (`cfg_in[5]`=0), when a word ends with the holding word empty, `sdo` keeps the word's last bit through later falling edges.
- R7: In single-word mode (`cfg_in[5]`=1), when a word ends with the holding word empty, `sdo` goes to 0 and stays there until a write is made and a falling edge loads it. The channel then sends exactly one word.
- R8: `cfg_we` updates the configuration only while `enable` is low. While enabled, it has no effect.
- R9: Dropping `enable` clears the shifter, the bit count, the holding word's full state and `buf_empty`, so `sdo` and `buf_empty` read 0. The configuration is kept.
- R10: A falling edge on `ext_clk` that arrives before system clock edge k changes `sdo` after edge k+2, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel on; a high-to-low change clears the channel |
| cfg_we | input | 1 | Strobe that loads `cfg_in` while disabled |
| cfg_in | input | 6 | [4:0] word length minus one, [5] single-word mode |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 32 | Word to send, bit 0 first |
| ext_clk | input | 1 | External shift clock, asynchronous to `clk` |
| sdo | output | 1 | Serial data out |
| buf_empty | output | 1 | Holding word has been taken by the shifter |

## Verification
The hardest situation to reach from the ports is a word boundary. On one falling edge the word ends, the holding word may be taken, and a new write may arrive in the same period. Whether the line then reloads, holds its last bit or goes low depends on the mode and on the holding state. The stimulus drives `ext_clk` as whole bit periods of eight system clocks and places writes just before chosen boundaries. It goes through 8-bit, 32-bit and 1-bit words in both modes, sends a configuration write while the channel is running, and measures the exact three-edge latency from the external clock input to the line.

// File: rtl/sst_pkg.sv
package sst_pkg;

  localparam int SST_MAX_W = 32;
  localparam int SST_LEN_W = $clog2(SST_MAX_W);
  localparam int SST_CFG_W = SST_LEN_W + 1;

  typedef struct packed {
    logic                 one_shot;
    logic [SST_LEN_W-1:0] len_m1;
  } sst_cfg_t;

  localparam sst_cfg_t SST_CFG_RESET = '{one_shot: 1'b0, len_m1: SST_LEN_W'(7)};

  function automatic sst_cfg_t sst_unpack(input logic [SST_CFG_W-1:0] raw);
    sst_cfg_t c;
    c.one_shot = raw[SST_LEN_W];
    c.len_m1   = raw[SST_LEN_W-1:0];
    return c;
  endfunction

endpackage

// File: rtl/sst_clk_sync.sv
module sst_clk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_in,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], ext_in};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~chain_q[STAGES-1];

  // R10: a detected fall is a one-cycle pulse
  p_fall_single_r10: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall) else $error("fall pulse longer than one cycle");

endmodule

// File: rtl/sst_holdbuf.sv
module sst_holdbuf #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_q,
  output logic              hold_full,
  output logic              buf_empty
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      buf_empty <= 1'b0;
    end else if (!enable) begin
      hold_full <= 1'b0;
      buf_empty <= 1'b0;
    end else begin
      if (take) begin
        hold_full <= 1'b0;
        buf_empty <= 1'b1;
      end
      if (wr_en) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
        buf_empty <= 1'b0;
      end
    end
  end

  p_flag_clear_on_write_r5: assert property (@(posedge clk) disable iff (rst)
    (enable && wr_en) |=> !buf_empty) else $error("flag set after write");

  p_flag_set_on_take_r5: assert property (@(posedge clk) disable iff (rst)
    (enable && take && !wr_en) |=> buf_empty) else $error("flag missing after take");

  p_disabled_flag_low_r9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!buf_empty && !hold_full)) else $error("flag or full kept while disabled");

endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fall,
  input  logic [DATA_W-1:0] hold_q,
  input  logic              hold_full,
  input  logic [CNT_W-1:0]  word_len,
  input  logic              one_shot,
  output logic              take,
  output logic              sdo
);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  bits_q;
  logic              en_q;
  logic              word_end;

  assign word_end = (bits_q <= CNT_W'(1));
  assign take     = enable & fall & word_end & hold_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      bits_q <= '0;
      en_q   <= 1'b0;
    end else begin
      en_q <= enable;
      if (!enable) begin
        if (wr_en) begin
          sh_q   <= wr_data;
          bits_q <= word_len;
        end else if (en_q) begin
          sh_q   <= '0;
          bits_q <= '0;
        end
      end else if (fall) begin
        if (!word_end) begin
          sh_q   <= sh_q >> 1;
          bits_q <= bits_q - CNT_W'(1);
        end else if (hold_full) begin
          sh_q   <= hold_q;
          bits_q <= word_len;
        end else begin
          bits_q <= '0;
          if (one_shot) sh_q <= '0;
        end
      end
    end
  end

  assign sdo = sh_q[0];

  p_refill_len_r4: assert property (@(posedge clk) disable iff (rst)
    take |=> (bits_q == $past(word_len))) else $error("refill length wrong");

  p_still_without_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (enable && !fall) |=> $stable(sdo)) else $error("sdo moved without clock edge");

  p_idle_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (enable && bits_q == '0 && !hold_full) |=> $stable(sdo)) else $error("idle line moved");

  p_single_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
    (enable && one_shot && bits_q == '0) |-> !sdo) else $error("single-word idle not low");

endmodule

// File: rtl/sst_tx_top.sv
module sst_tx_top
  import sst_pkg::*;
#(
  parameter int DATA_W      = SST_MAX_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic                 cfg_we,
  input  logic [SST_CFG_W-1:0] cfg_in,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 ext_clk,
  output logic                 sdo,
  output logic                 buf_empty
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  sst_cfg_t          cfg_q;
  logic [CNT_W-1:0]  word_len;
  logic              fall;
  logic              take;
  logic [DATA_W-1:0] hold_q;
  logic              hold_full;

  always_ff @(posedge clk) begin
    if (rst)                    cfg_q <= SST_CFG_RESET;
    else if (cfg_we && !enable) cfg_q <= sst_unpack(cfg_in);
  end

  assign word_len = CNT_W'(cfg_q.len_m1) + CNT_W'(1);

  sst_clk_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .ext_in(ext_clk), .fall(fall)
  );

  sst_holdbuf #(.DATA_W(DATA_W)) hold_i (
    .clk(clk), .rst(rst), .enable(enable), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .hold_q(hold_q), .hold_full(hold_full), .buf_empty(buf_empty)
  );

  sst_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) shift_i (
    .clk(clk), .rst(rst), .enable(enable), .wr_en(wr_en), .wr_data(wr_data),
    .fall(fall), .hold_q(hold_q), .hold_full(hold_full), .word_len(word_len),
    .one_shot(cfg_q.one_shot), .take(take), .sdo(sdo)
  );

  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    enable |=> $stable(cfg_q)) else $error("config changed while enabled");

endmodule

// File: tb/sst_tx_top_tb_top.sv
module sst_tx_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_in = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        ext_clk = 1'b0;
  logic        sdo;
  logic        buf_empty;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit started = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sst_tx_top dut_i (
    .clk(clk), .rst(rst), .enable(enable), .cfg_we(cfg_we), .cfg_in(cfg_in),
    .wr_en(wr_en), .wr_data(wr_data), .ext_clk(ext_clk), .sdo(sdo), .buf_empty(buf_empty)
  );

  // behavioural reference
  logic [31:0] m_sh, m_hold;
  int m_bits, m_len;
  bit m_full, m_flag, m_ss, m_enq, e1, e2, e3, m_fall;

  always @(posedge clk) begin
    m_fall = e3 && !e2;
    e3 = e2; e2 = e1; e1 = ext_clk;
    if (rst) begin
      m_sh = 0; m_hold = 0; m_bits = 0; m_len = 8; m_full = 0; m_flag = 0;
      m_ss = 0; m_enq = 0; e1 = 0; e2 = 0; e3 = 0;
    end else begin
      if (enable) begin
        if (m_fall) begin
          if (m_bits > 1) begin m_sh = m_sh >> 1; m_bits--; end
          else if (m_full) begin m_sh = m_hold; m_bits = m_len; m_full = 0; m_flag = 1; end
          else begin m_bits = 0; if (m_ss) m_sh = 0; end
        end
        if (wr_en) begin m_hold = wr_data; m_full = 1; m_flag = 0; end
      end else begin
        m_full = 0; m_flag = 0;
        if (wr_en) begin m_sh = wr_data; m_bits = m_len; end
        else if (m_enq) begin m_sh = 0; m_bits = 0; end
        if (cfg_we) begin m_len = int'(cfg_in[4:0]) + 1; m_ss = cfg_in[5]; end
      end
      m_enq = enable;
    end
    started = 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      check(sdo == m_sh[0], "R3 lockstep sdo", 32'(sdo), 32'(m_sh[0]));
      check(buf_empty == m_flag, "R5 lockstep buf_empty", 32'(buf_empty), 32'(m_flag));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); #2; endtask
  task automatic ticks(input int n); for (int i = 0; i < n; i++) tick(); endtask
  task automatic wr(input logic [31:0] d); wr_en = 1; wr_data = d; tick(); wr_en = 0; endtask
  task automatic cfg(input logic [5:0] v); cfg_we = 1; cfg_in = v; tick(); cfg_we = 0; endtask
  task automatic set_en(input logic v); enable = v; tick(); endtask
  task automatic pulse(output logic b);
    ext_clk = 1; ticks(4); b = sdo; ext_clk = 0; ticks(4);
  endtask
  task automatic recv(input int n, output logic [31:0] w);
    logic b;
    w = '0;
    for (int i = 0; i < n; i++) begin pulse(b); w[i] = b; end
  endtask

  logic [31:0] w;
  logic b;

  initial begin
    ticks(3); rst = 0; tick();
    check(sdo == 0, "R1 reset sdo", 32'(sdo), 0);
    check(buf_empty == 0, "R1 reset buf_empty", 32'(buf_empty), 0);

    // default 8-bit continuous
    wr(32'hA5);
    check(sdo == 1, "R2 direct load bit0", 32'(sdo), 1);
    set_en(1);
    wr(32'hBC);
    check(buf_empty == 0, "R5 flag low while hold full", 32'(buf_empty), 0);
    recv(8, w);
    check(w == 32'hA5, "R1 R3 default 8-bit word", w, 32'hA5);
    check(buf_empty == 1, "R5 flag after transfer", 32'(buf_empty), 1);
    check(sdo == 0, "R4 seamless reload bit0", 32'(sdo), 0);
    recv(8, w);
    check(w == 32'hBC, "R4 second word", w, 32'hBC);
    for (int i = 0; i < 3; i++) begin
      pulse(b);
      check(b == 1, "R6 hold last bit", 32'(b), 1);
    end

    // single-word 32-bit
    set_en(0);
    check(sdo == 0, "R9 disable clears sdo", 32'(sdo), 0);
    check(buf_empty == 0, "R9 disable clears flag", 32'(buf_empty), 0);
    cfg(6'h3F);
    set_en(1);
    wr(32'hDEADBEEF);
    check(sdo == 0, "R7 idle before load", 32'(sdo), 0);
    pulse(b);
    recv(32, w);
    check(w == 32'hDEADBEEF, "R3 R7 32-bit word", w, 32'hDEADBEEF);
    check(sdo == 0, "R7 idle low after word", 32'(sdo), 0);
    pulse(b);
    check(b == 0, "R7 stays idle", 32'(b), 0);

    // config write while enabled is ignored
    cfg(6'h03);
    wr(32'h000000F5);
    pulse(b);
    recv(32, w);
    check(w == 32'h000000F5, "R8 length kept at 32", w, 32'hF5);
    check(sdo == 0, "R8 mode kept single-word", 32'(sdo), 0);

    // 1-bit continuous, latency
    set_en(0);
    cfg(6'h00);
    wr(32'h1);
    check(sdo == 1, "R2 direct load len1", 32'(sdo), 1);
    set_en(1);
    wr(32'h0);
    pulse(b);
    check(b == 1, "R3 1-bit word", 32'(b), 1);
    check(buf_empty == 1, "R5 flag after 1-bit transfer", 32'(buf_empty), 1);
    check(sdo == 0, "R4 1-bit reload", 32'(sdo), 0);
    wr(32'h1);
    check(buf_empty == 0, "R5 write clears flag", 32'(buf_empty), 0);
    ext_clk = 1; ticks(4);
    ext_clk = 0;
    tick(); tick();
    check(sdo == 0, "R10 no change after two edges", 32'(sdo), 0);
    tick();
    check(sdo == 1, "R10 change on third edge", 32'(sdo), 1);
    ticks(4);
    pulse(b);
    check(sdo == 1, "R6 1-bit hold", 32'(sdo), 1);

    // disable keeps configuration
    set_en(0);
    set_en(1);
    wr(32'h1);
    pulse(b);
    wr(32'h0);
    pulse(b);
    check(buf_empty == 1, "R9 length kept across disable", 32'(buf_empty), 1);
    check(sdo == 0, "R9 second 1-bit word", 32'(sdo), 0);

    ticks(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule